// File: doc/BRIEF.md
# UART Host Register Front-End with Banked Divisor

This block is the register side of a 16550-class serial port. A host reaches it over a small byte-wide bus with a three-bit address, a write strobe, a read strobe and separate write and read data. It keeps the line settings, the modem line settings, the interrupt source mask, the FIFO settings and a 16-bit baud divisor. It also holds the most recently received byte together with its data-ready flag. The transmit and receive shift engines and the interrupt prioritiser sit outside this block. They connect through a load strobe, a capture strobe, a status byte and an identification code.

The top bit of the line settings register is the bank select. While it is set, addresses 0 and 1 reach the two divisor bytes rather than the data path and the interrupt mask. A baud tick generator divides the input clock by the divisor. With the loopback bit set, a byte written for transmission goes straight into the receive holding register. The serial pin then rests at mark and the modem pins are released.

Top module: `uart_reg_front`

## Requirements
- R1: After reset, the line settings, modem settings, interrupt mask, FIFO settings and divisor are all zero. Data-ready is clear, no baud tick is produced, the DTR and RTS pins are low, and the serial output follows the engine's output.
- R2: While line settings bit 7 (bank select) is set, a write to address 0 sets divisor bits 7:0 and a write to address 1 sets divisor bits 15:8, and reads of those addresses return those bytes. Such writes leave the interrupt mask unchanged and produce no transmit load.
- R3: With bank select clear, a write to address 0 and loopback off pulses `tx_load` in the same cycle with `tx_byte` equal to the written byte. A write to address 1 stores bits 3:0 as the interrupt mask: bit 0 received data, bit 1 transmit empty, bit 2 line status, bit 3 modem status. The mask reads back at address 1 with bits 7:4 zero.
- R4: Address 3 holds the line settings: bits 1:0 word length, bit 2 extra stop bit, bit 3 parity enable, bit 4 even parity, bit 5 stick parity, bit 6 break. All bits read back. Outside loopback, break forces the serial output low.
- R5: Address 4 holds the modem settings: bit 0 DTR, bit 1 RTS, bit 2 user output, bit 3 interrupt output enable, bit 4 loopback. It reads back with bits 7:5 zero. Outside loopback, the DTR and RTS pins follow bits 0 and 1, active high, and `irq_out_en` follows bit 3.
- R6: In loopback, a write to address 0 with bank select clear stores the byte in the receive holding register and sets data-ready, with no `tx_load`. The serial output is held at 1 even under break, DTR and RTS pins are low, and `rx_valid` from the engine is ignored.
- R7: Outside loopback, `rx_valid` stores `rx_byte` and sets data-ready (status bit 0). A read of address 0 with bank select clear returns the held byte and clears data-ready, unless a new byte is captured in that same cycle.
- R8: With divisor 0, `baud_tick` stays low. With divisor N > 0, it pulses high for one cycle every N clocks.
- R9: A write to address 2 stores bit 0 as FIFO enable and bits 7:6 as the trigger level. Bit 1 pulses `rx_flush` and bit 2 pulses `tx_flush` in the write cycle, and neither is stored. A read of address 2 returns `iir_code` in bits 5:0, with bits 7:6 both set when FIFO enable is set and both clear otherwise.
- R10: A read of address 5 returns data-ready in bit 0 and `lsr_status[6:0]` in bits 7:1. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| tx_load | output | 1 | Transmit engine load strobe |
| tx_byte | output | 8 | Byte for the transmit engine |
| rx_valid | input | 1 | Receive engine capture strobe |
| rx_byte | input | 8 | Byte from the receive engine |
| lsr_status | input | 7 | Line status bits 7:1 from the engines |
| iir_code | input | 6 | Interrupt identification bits 5:0 |
| ser_from_engine | input | 1 | Serial bit from the transmit engine |
| ser_out | output | 1 | Serial output pin |
| dtr_pin | output | 1 | DTR pin, active high |
| rts_pin | output | 1 | RTS pin, active high |
| irq_out_en | output | 1 | Interrupt output enable |
| lcr_cfg | output | 8 | Line settings to the engines |
| ier_mask | output | 4 | Interrupt mask to the prioritiser |
| fifo_en | output | 1 | FIFO enable |
| fifo_trig | output | 2 | FIFO trigger level |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| baud_tick | output | 1 | Baud rate tick |

## Verification
The embedded properties watch, on every cycle, that banked writes land in the divisor and leave the interrupt mask alone. They also check that a loopback write arrives in the holding register with data-ready set, that a data read clears data-ready, and that the tick is silent with divisor zero and never repeats back-to-back for divisors above one. Only the directed scenarios can show the exact tick spacing for several divisors and the pin behaviour under break and loopback. The same holds for the read-back layouts of every address and the flush pulses with their non-storage.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int DIV_W   = 2 * BYTE_W;
    localparam int MASK_W  = 4;
    localparam int TRIG_W  = 2;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
    localparam logic [ADDR_W-1:0] A_FIFO = 3'd2;
    localparam logic [ADDR_W-1:0] A_LINE = 3'd3;
    localparam logic [ADDR_W-1:0] A_MDM  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

    typedef struct packed {
        logic       bank;
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_on;
        logic       stop2;
        logic [1:0] wlen;
    } line_cfg_t;

    typedef struct packed {
        logic loop;
        logic irq_en;
        logic user1;
        logic rts;
        logic dtr;
    } mdm_cfg_t;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } bg_state_t;

    bg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (div_i == '0) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else if (st_q.cnt >= div_i - DIV_W'(1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + DIV_W'(1);
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    p_tick_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |=> !tick_o);
    p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i > DIV_W'(1)) |=> !tick_o);
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_i,
    input  logic              loop_wr_i,
    input  logic [BYTE_W-1:0] loop_byte_i,
    input  logic              ext_valid_i,
    input  logic [BYTE_W-1:0] ext_byte_i,
    input  logic              rd_clr_i,
    output logic [BYTE_W-1:0] hold_o,
    output logic              ready_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic              ready;
    } rh_state_t;

    rh_state_t st_d, st_q;
    logic      ext_cap;

    assign ext_cap = ext_valid_i && !loop_i;

    always_comb begin
        st_d = st_q;
        if (rd_clr_i) st_d.ready = 1'b0;
        if (loop_wr_i) begin
            st_d.hold  = loop_byte_i;
            st_d.ready = 1'b1;
        end else if (ext_cap) begin
            st_d.hold  = ext_byte_i;
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o  = st_q.hold;
    assign ready_o = st_q.ready;

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !loop_wr_i && !(ext_valid_i && !loop_i)) |=> !ready_o);
    p_ext_ignored_loop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_i && !loop_wr_i && !rd_clr_i) |=> $stable(hold_o));
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output line_cfg_t         line_o,
    output mdm_cfg_t          mdm_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              fifo_en_o,
    output logic [TRIG_W-1:0] trig_o,
    output logic [DIV_W-1:0]  div_o
);
    typedef struct packed {
        line_cfg_t         line;
        mdm_cfg_t          mdm;
        logic [MASK_W-1:0] mask;
        logic              fifo_en;
        logic [TRIG_W-1:0] trig;
        logic [DIV_W-1:0]  div;
    } cr_state_t;

    cr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            unique case (addr_i)
                A_DATA: if (st_q.line.bank) st_d.div[BYTE_W-1:0] = wdata_i;
                A_MASK: begin
                    if (st_q.line.bank) st_d.div[DIV_W-1:BYTE_W] = wdata_i;
                    else                st_d.mask = wdata_i[MASK_W-1:0];
                end
                A_FIFO: begin
                    st_d.fifo_en = wdata_i[0];
                    st_d.trig    = wdata_i[BYTE_W-1 -: TRIG_W];
                end
                A_LINE: st_d.line = line_cfg_t'(wdata_i);
                A_MDM:  st_d.mdm  = mdm_cfg_t'(wdata_i[$bits(mdm_cfg_t)-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o    = st_q.line;
    assign mdm_o     = st_q.mdm;
    assign mask_o    = st_q.mask;
    assign fifo_en_o = st_q.fifo_en;
    assign trig_o    = st_q.trig;
    assign div_o     = st_q.div;

    p_div_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_DATA && line_o.bank)
        |=> div_o[BYTE_W-1:0] == $past(wdata_i));
    p_div_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MASK && line_o.bank)
        |=> div_o[DIV_W-1:BYTE_W] == $past(wdata_i));
    p_mask_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MASK && line_o.bank) |=> $stable(mask_o));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
    import uart_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        tx_load,
    output logic [7:0]  tx_byte,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic [6:0]  lsr_status,
    input  logic [5:0]  iir_code,
    input  logic        ser_from_engine,
    output logic        ser_out,
    output logic        dtr_pin,
    output logic        rts_pin,
    output logic        irq_out_en,
    output logic [7:0]  lcr_cfg,
    output logic [3:0]  ier_mask,
    output logic        fifo_en,
    output logic [1:0]  fifo_trig,
    output logic        rx_flush,
    output logic        tx_flush,
    output logic        baud_tick
);
    line_cfg_t         line;
    mdm_cfg_t          mdm;
    logic [MASK_W-1:0] mask;
    logic              fen;
    logic [TRIG_W-1:0] trig;
    logic [DIV_W-1:0]  div;
    logic [BYTE_W-1:0] hold;
    logic              ready;
    logic              data_wr, loop_wr, data_rd;

    assign data_wr = bus_wr && bus_addr == A_DATA && !line.bank;
    assign loop_wr = data_wr && mdm.loop;
    assign data_rd = bus_rd && bus_addr == A_DATA && !line.bank;

    uart_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .line_o(line), .mdm_o(mdm), .mask_o(mask),
        .fifo_en_o(fen), .trig_o(trig), .div_o(div)
    );

    uart_rx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .loop_i(mdm.loop), .loop_wr_i(loop_wr),
        .loop_byte_i(bus_wdata), .ext_valid_i(rx_valid), .ext_byte_i(rx_byte),
        .rd_clr_i(data_rd), .hold_o(hold), .ready_o(ready)
    );

    uart_baud_gen u_baud (
        .clk(clk), .rst_n(rst_n), .div_i(div), .tick_o(baud_tick)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_DATA: bus_rdata = line.bank ? div[BYTE_W-1:0] : hold;
            A_MASK: bus_rdata = line.bank ? div[DIV_W-1:BYTE_W]
                                          : {{(BYTE_W-MASK_W){1'b0}}, mask};
            A_FIFO: bus_rdata = {{TRIG_W{fen}}, iir_code};
            A_LINE: bus_rdata = line;
            A_MDM:  bus_rdata = {{(BYTE_W-$bits(mdm_cfg_t)){1'b0}}, mdm};
            A_STAT: bus_rdata = {lsr_status, ready};
            default: bus_rdata = '0;
        endcase
    end

    assign tx_load    = data_wr && !mdm.loop;
    assign tx_byte    = bus_wdata;
    assign ser_out    = mdm.loop ? 1'b1 : (line.brk ? 1'b0 : ser_from_engine);
    assign dtr_pin    = mdm.dtr && !mdm.loop;
    assign rts_pin    = mdm.rts && !mdm.loop;
    assign irq_out_en = mdm.irq_en;
    assign lcr_cfg    = line;
    assign ier_mask   = mask;
    assign fifo_en    = fen;
    assign fifo_trig  = trig;
    assign rx_flush   = bus_wr && bus_addr == A_FIFO && bus_wdata[1];
    assign tx_flush   = bus_wr && bus_addr == A_FIFO && bus_wdata[2];

    p_loop_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loop_wr |=> (ready && hold == $past(bus_wdata)));
    p_bank_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line.bank |-> !tx_load);
endmodule

// File: tb/sim_uart_reg_front.sv
module sim_uart_reg_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_load;
    logic [7:0] tx_byte;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [6:0] lsr_status = '0;
    logic [5:0] iir_code = 6'h01;
    logic       ser_from_engine = 1'b1;
    logic       ser_out, dtr_pin, rts_pin, irq_out_en;
    logic [7:0] lcr_cfg;
    logic [3:0] ier_mask;
    logic       fifo_en;
    logic [1:0] fifo_trig;
    logic       rx_flush, tx_flush, baud_tick;

    int checks = 0, failures = 0;
    longint cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_reg_front u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic gap(output int g);
        longint t1 = -1;
        g = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (baud_tick) begin
                if (t1 < 0) t1 = cyc;
                else begin g = int'(cyc - t1); break; end
            end
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd3, d); chk("R1 line", d, 8'h00);
        rd(3'd4, d); chk("R1 modem", d, 8'h00);
        rd(3'd1, d); chk("R1 mask", d, 8'h00);
        rd(3'd5, d); chk("R1 ready", d[0], 1'b0);
        chk("R1 pins", {dtr_pin, rts_pin, ser_out, baud_tick}, 4'b0010);
        chk("R1 fifo", {fifo_en, fifo_trig}, 3'b000);
    endtask

    task automatic t_data();
        logic [7:0] d;
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'hA5; bus_wr = 1'b1;
        #2 chk("R3 tx_load", {tx_load, tx_byte}, {1'b1, 8'hA5});
        @(posedge clk); #1; bus_wr = 1'b0;
        #2 chk("R3 tx_load drops", tx_load, 1'b0);
        wr(3'd1, 8'hFB);
        rd(3'd1, d); chk("R3 mask readback", d, 8'h0B);
        chk("R3 mask out", ier_mask, 4'hB);
    endtask

    task automatic t_divisor();
        logic [7:0] d;
        wr(3'd3, 8'h80);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h2C; bus_wr = 1'b1;
        #2 chk("R2 no load", tx_load, 1'b0);
        @(posedge clk); #1; bus_wr = 1'b0;
        wr(3'd1, 8'h01);
        rd(3'd0, d); chk("R2 div low", d, 8'h2C);
        rd(3'd1, d); chk("R2 div high", d, 8'h01);
        chk("R2 mask kept", ier_mask, 4'hB);
        wr(3'd3, 8'h00);
        rd(3'd1, d); chk("R2 mask after unbank", d, 8'h0B);
    endtask

    task automatic t_baud();
        int g;
        gap(g); chk("R8 div 300", g, 300);
        wr(3'd3, 8'h80); wr(3'd1, 8'h00); wr(3'd0, 8'h04); wr(3'd3, 8'h00);
        gap(g); chk("R8 div 4", g, 4);
        wr(3'd3, 8'h80); wr(3'd0, 8'h01); wr(3'd3, 8'h00);
        gap(g); chk("R8 div 1", g, 1);
        wr(3'd3, 8'h80); wr(3'd0, 8'h00); wr(3'd3, 8'h00);
        repeat (3) @(negedge clk);
        g = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (baud_tick) g++; end
        chk("R8 div 0 silent", g, 0);
    endtask

    task automatic t_line();
        logic [7:0] d;
        wr(3'd3, 8'h3F);
        rd(3'd3, d); chk("R4 readback", d, 8'h3F);
        chk("R4 cfg out", lcr_cfg, 8'h3F);
        chk("R4 no break", ser_out, 1'b1);
        wr(3'd3, 8'h40);
        #2 chk("R4 break", ser_out, 1'b0);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_modem();
        logic [7:0] d;
        wr(3'd4, 8'hEF);
        rd(3'd4, d); chk("R5 readback", d, 8'h0F);
        chk("R5 pins", {dtr_pin, rts_pin, irq_out_en}, 3'b111);
        wr(3'd4, 8'h02);
        chk("R5 pins rts only", {dtr_pin, rts_pin, irq_out_en}, 3'b010);
    endtask

    task automatic t_loop();
        logic [7:0] d;
        wr(3'd4, 8'h13);
        wr(3'd3, 8'h40);
        #2 chk("R6 pins released", {dtr_pin, rts_pin, ser_out}, 3'b001);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h5A; bus_wr = 1'b1;
        #2 chk("R6 no load", tx_load, 1'b0);
        @(posedge clk); #1; bus_wr = 1'b0;
        @(negedge clk); rx_byte = 8'hEE; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        rd(3'd5, d); chk("R6 ready", d[0], 1'b1);
        rd(3'd0, d); chk("R6 echo", d, 8'h5A);
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    endtask

    task automatic t_rx();
        logic [7:0] d;
        @(negedge clk); rx_byte = 8'h3C; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        rd(3'd5, d); chk("R7 ready set", d[0], 1'b1);
        rd(3'd0, d); chk("R7 byte", d, 8'h3C);
        rd(3'd5, d); chk("R7 ready cleared", d[0], 1'b0);
    endtask

    task automatic t_fifo();
        logic [7:0] d;
        @(negedge clk);
        bus_addr = 3'd2; bus_wdata = 8'hC7; bus_wr = 1'b1;
        #2 chk("R9 flush pulses", {rx_flush, tx_flush}, 2'b11);
        @(posedge clk); #1; bus_wr = 1'b0;
        #2 chk("R9 flush end", {rx_flush, tx_flush}, 2'b00);
        chk("R9 cfg", {fifo_en, fifo_trig}, 3'b111);
        iir_code = 6'h0C;
        rd(3'd2, d); chk("R9 id enabled", d, 8'hCC);
        wr(3'd2, 8'h40);
        rd(3'd2, d); chk("R9 id disabled", d, 8'h0C);
        chk("R9 trig", fifo_trig, 2'b01);
    endtask

    task automatic t_status();
        logic [7:0] d;
        lsr_status = 7'b0110000;
        rd(3'd5, d); chk("R10 status", d, 8'h60);
        rd(3'd6, d); chk("R10 addr6", d, 8'h00);
        rd(3'd7, d); chk("R10 addr7", d, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_data();
        t_divisor();
        t_baud();
        t_line();
        t_modem();
        t_loop();
        t_rx();
        t_fifo();
        t_status();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule